// File: doc/BRIEF.md
# Frame-Aligned Elastic Store with Controlled Slip

This block absorbs the rate difference between a serial bit stream arriving at line rate and a local read clock, for a stream built from 193-bit frames: one framing bit followed by 192 payload bits. The two rates appear as enable strobes on a single system clock. `wr_en` offers one incoming bit and `rd_en` asks for one outgoing bit. The storage holds two complete frames and works as a pair of frame slots. Reading begins one frame behind writing, which leaves half a frame of margin in each direction before the store would overrun.

Slip decisions are made only when the read side is about to emit a framing bit. If the distance from write to read is above one and a half frames at that moment, reading jumps to the other slot, so one whole frame is deleted. If the distance is below half a frame, reading goes back to the other slot, so the previous frame is read again. In both cases the read output keeps its frame cadence: a framing bit still opens every frame, and alignment is never lost. Each slip raises a single-cycle flag and advances a 16-bit slip counter.

A three-state controller sequences the block:
- `ST_HUNT` ignores writes until a write arrives that is marked as a frame start. That write moves it to `ST_FILL`.
- `ST_FILL` discards reads until one full frame has been stored. It then moves to `ST_RUN`.
- `ST_RUN` stays in place until reset.

Top module: `frame_slip_buffer`

## Requirements
- R1: During and right after reset, `rd_valid`, `rd_sof`, `slip_delete` and `slip_repeat` are 0 and `slip_count` is 0.
- R2: Writes that come before the first write with `wr_sof`=1 are discarded. That marked bit becomes the first bit of stored frame 0.
- R3: `rd_en` has no effect until 193 bits have been stored after the first marked write. After that, each `rd_en` gives `rd_valid`=1 in the next cycle, together with the next bit on `rd_bit`.
- R4: `rd_sof` is 1 on the first valid read output, and then on every 193rd valid read output, including across slips.
- R5: At a read frame start, if the fill (accepted writes minus reads, counted in bits) is above 289, one whole stored frame is skipped and `slip_delete` pulses together with that `rd_sof`.
- R6: At a read frame start, if the fill is below 97, the previous stored frame is read again and `slip_repeat` pulses together with that `rd_sof`.
- R7: A fill from 97 to 289 at a frame start causes no slip, so a transient read or write pause of up to about 75 bits is absorbed.
- R8: `slip_count` rises by exactly one on the same edge as each slip flag, and it never changes otherwise.
- R9: The first bit of every read frame is a framing bit that was written with `wr_sof`=1. The bench writes it as 1.
- R10: When the write and read rates are equal, frames are read whole and in write order, with no slip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe: one line bit is offered |
| wr_bit | input | 1 | Incoming bit |
| wr_sof | input | 1 | Incoming bit is the framing bit of a frame |
| rd_en | input | 1 | Read strobe: one local bit is requested |
| rd_valid | output | 1 | A read bit is presented this cycle |
| rd_bit | output | 1 | Outgoing bit |
| rd_sof | output | 1 | Outgoing bit is a framing bit |
| slip_delete | output | 1 | One frame was dropped at this frame start |
| slip_repeat | output | 1 | One frame was repeated at this frame start |
| slip_count | output | 16 | Running total of controlled slips |

## Verification
A slip decision and a write can fall in the same cycle: the read pointer switches slots at a frame start while the write side is storing a bit, possibly into the slot being left. The bench provokes this with sustained offsets in both directions, from overlapping write and read strobe patterns, so writes happen on most read frame starts. It judges the outcome by writing numbered frames and comparing every read bit, every frame-start flag and every slip flag against a bit-position model of the stream. A frame that was corrupted by the concurrent write, or a slip landing one frame off, shows up as a wrong frame number or a wrong framing bit.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } fsb_state_e;

endpackage

// File: rtl/fsb_store.sv
module fsb_store #(
    parameter int FB = 193,
    localparam int DEPTH = 2 * FB,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          wbit,
    input  logic          wsof,
    input  logic [PW-1:0] raddr,
    output logic [PW-1:0] wptr,
    output logic          rdata
);
    localparam logic [PW-1:0] SLOT_B  = PW'(FB);
    localparam logic [PW-1:0] LOW_EDG = PW'(FB / 2);
    localparam logic [PW-1:0] HI_EDG  = PW'(FB + FB / 2);
    localparam logic [PW-1:0] LAST    = PW'(DEPTH - 1);

    logic [DEPTH-1:0] mem;
    logic [PW-1:0]    waddr;

    // a marked bit snaps to the base of the nearer slot
    always_comb begin
        waddr = wptr;
        if (wsof) begin
            waddr = (wptr >= LOW_EDG && wptr < HI_EDG) ? SLOT_B : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            mem  <= '0;
        end else if (we) begin
            mem[waddr] <= wbit;
            wptr       <= (waddr == LAST) ? '0 : waddr + 1'b1;
        end
    end

    assign rdata = mem[raddr];

    assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wptr <= LAST);

    assert_sof_slot_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wsof) |=> (wptr == PW'(1) || wptr == PW'(FB + 1)));

endmodule

// File: rtl/fsb_reader.sv
module fsb_reader
    import fsb_pkg::*;
#(
    parameter int FB = 193,
    localparam int DEPTH = 2 * FB,
    localparam int PW = $clog2(DEPTH),
    localparam int FW = $clog2(FB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sof,
    input  logic [PW-1:0] wptr,
    input  logic          rd_en,
    input  logic          rdata,
    output logic          wr_accept,
    output logic [PW-1:0] raddr,
    output logic          slip_bump,
    output logic          rd_valid,
    output logic          rd_bit,
    output logic          rd_sof,
    output logic          slip_delete,
    output logic          slip_repeat
);
    localparam logic [PW-1:0] SLOT_B = PW'(FB);
    localparam logic [PW-1:0] LAST   = PW'(DEPTH - 1);
    localparam logic [FW-1:0] F_LAST = FW'(FB - 1);
    localparam logic [PW:0]   HI_MK  = (PW+1)'(FB + FB / 2);
    localparam logic [PW:0]   LO_MK  = (PW+1)'(FB / 2 + 1);

    fsb_state_e    state, nxt;
    logic [PW-1:0] rp, other;
    logic [FW-1:0] fcnt;
    logic [PW:0]   fill;
    logic          take, at_frame, want_del, want_rep;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT: if (wr_en && wr_sof) nxt = ST_FILL;
            ST_FILL: if (wptr == SLOT_B)  nxt = ST_RUN;
            ST_RUN:  nxt = ST_RUN;
            default: nxt = ST_HUNT;
        endcase
    end

    assign wr_accept = wr_en && (state != ST_HUNT || wr_sof);

    always_comb begin
        fill = (wptr >= rp) ? ({1'b0, wptr} - {1'b0, rp})
                            : ({1'b0, wptr} + (PW+1)'(DEPTH) - {1'b0, rp});
        take     = rd_en && (state == ST_RUN);
        at_frame = (fcnt == '0);
        want_del = take && at_frame && (fill > HI_MK);
        want_rep = take && at_frame && (fill < LO_MK);
        other    = (rp >= SLOT_B) ? rp - SLOT_B : rp + SLOT_B;
        raddr    = (want_del || want_rep) ? other : rp;
    end

    assign slip_bump = want_del || want_rep;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp   <= '0;
            fcnt <= '0;
        end else if (take) begin
            rp   <= (raddr == LAST) ? '0 : raddr + 1'b1;
            fcnt <= (fcnt == F_LAST) ? '0 : fcnt + 1'b1;
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid    <= 1'b0;
            rd_bit      <= 1'b0;
            rd_sof      <= 1'b0;
            slip_delete <= 1'b0;
            slip_repeat <= 1'b0;
        end else begin
            rd_valid    <= take;
            rd_sof      <= take && at_frame;
            slip_delete <= want_del;
            slip_repeat <= want_rep;
            if (take) rd_bit <= rdata;
        end
    end

    // checker state: valid reads since the last frame start
    logic [FW-1:0] gap;
    logic          seen_sof;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap      <= '0;
            seen_sof <= 1'b0;
        end else if (rd_valid) begin
            if (rd_sof) begin
                gap      <= '0;
                seen_sof <= 1'b1;
            end else begin
                gap <= gap + 1'b1;
            end
        end
    end

    assert_sof_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_sof && seen_sof) |-> (gap == F_LAST));

    assert_first_is_sof_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !seen_sof) |-> rd_sof);

    assert_slip_on_sof_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_delete || slip_repeat) |-> (rd_sof && rd_valid));

    assert_single_slip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(slip_delete && slip_repeat));

    assert_quiet_before_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |=> !rd_valid);

endmodule

// File: rtl/fsb_slip_count.sv
module fsb_slip_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (bump) count <= count + 1'b1;
    end

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> (count == $past(count) + CNT_W'(1)));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(count));

endmodule

// File: rtl/frame_slip_buffer.sv
module frame_slip_buffer #(
    parameter int FRAME_BITS = 193,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             wr_sof,
    input  logic             rd_en,
    output logic             rd_valid,
    output logic             rd_bit,
    output logic             rd_sof,
    output logic             slip_delete,
    output logic             slip_repeat,
    output logic [CNT_W-1:0] slip_count
);
    localparam int PW = $clog2(2 * FRAME_BITS);

    logic [PW-1:0] wptr, raddr;
    logic          wr_accept, rdata, slip_bump;

    fsb_store #(.FB(FRAME_BITS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_accept),
        .wbit  (wr_bit),
        .wsof  (wr_sof),
        .raddr (raddr),
        .wptr  (wptr),
        .rdata (rdata)
    );

    fsb_reader #(.FB(FRAME_BITS)) u_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sof      (wr_sof),
        .wptr        (wptr),
        .rd_en       (rd_en),
        .rdata       (rdata),
        .wr_accept   (wr_accept),
        .raddr       (raddr),
        .slip_bump   (slip_bump),
        .rd_valid    (rd_valid),
        .rd_bit      (rd_bit),
        .rd_sof      (rd_sof),
        .slip_delete (slip_delete),
        .slip_repeat (slip_repeat)
    );

    fsb_slip_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (slip_bump),
        .count (slip_count)
    );

endmodule

// File: tb/frame_slip_buffer_test.sv
module frame_slip_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int FB = 193;
    localparam int CW = 16;
    localparam int HI_MK = FB + FB / 2;
    localparam int LO_MK = FB / 2 + 1;
    localparam int WATCHDOG = 190000;
    localparam int NSCN = 5;
    localparam int PAUSE_AT = 2000;
    // write skip period, read skip period, cycles, read pause, write pause, expected (0 none, 1 delete, 2 repeat)
    localparam int SCN [NSCN][6] = '{
        '{10,  8, 20000,  0,  0, 1},
        '{ 8, 10, 20000,  0,  0, 2},
        '{ 6,  6,  6000,  0,  0, 0},
        '{ 6,  6,  6000, 90,  0, 0},
        '{ 6,  6,  6000,  0, 90, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_bit = 1'b0, wr_sof = 1'b0, rd_en = 1'b0;
    logic rd_valid, rd_bit, rd_sof, slip_delete, slip_repeat;
    logic [CW-1:0] slip_count;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frame_slip_buffer #(.FRAME_BITS(FB), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .wr_sof(wr_sof),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_bit(rd_bit), .rd_sof(rd_sof),
        .slip_delete(slip_delete), .slip_repeat(slip_repeat), .slip_count(slip_count)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int  wcnt, rmod, ndel, nrep;
    bit  run;
    bit  e_valid, e_bit, e_sof, e_del, e_rep;
    int  e_pos;

    function automatic logic gen_bit(int pos);
        int k;
        int i;
        logic [7:0] n;
        k = pos / FB;
        i = pos % FB;
        n = k[7:0];
        if (i == 0) return 1'b1;
        return n[(i - 1) % 8];
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // compare last cycle's outputs, then drive one cycle of stimulus
    task automatic step(bit w, bit r, bit junk);
        int d;
        check(rd_valid == e_valid, "R3", "rd_valid", rd_valid, e_valid);
        if (e_valid) begin
            check(rd_bit == e_bit, e_sof ? "R9" : (e_pos < FB ? "R2" : "R10"),
                  "rd_bit", rd_bit, e_bit);
            check(rd_sof == e_sof, "R4", "rd_sof", rd_sof, e_sof);
            check(slip_delete == e_del, "R5", "slip_delete", slip_delete, e_del);
            check(slip_repeat == e_rep, "R6", "slip_repeat", slip_repeat, e_rep);
        end
        check(slip_count == CW'(ndel + nrep), "R8", "slip_count", slip_count, ndel + nrep);

        wr_en  = w;
        wr_sof = 1'b0;
        wr_bit = 1'b1;
        if (w && !junk) begin
            wr_bit = gen_bit(wcnt);
            wr_sof = (wcnt % FB == 0);
        end
        rd_en = r;
        e_valid = r && run;
        e_del = 0;
        e_rep = 0;
        e_sof = 0;
        if (e_valid) begin
            if (rmod % FB == 0) begin
                e_sof = 1;
                d = wcnt - rmod;
                if (d > HI_MK) begin
                    rmod += FB; e_del = 1; ndel++;
                end else if (d < LO_MK) begin
                    rmod -= FB; e_rep = 1; nrep++;
                end
            end
            e_bit = gen_bit(rmod);
            e_pos = rmod;
            rmod++;
        end
        if (w && !junk) wcnt++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 0; wr_bit = 0; wr_sof = 0; rd_en = 0;
        wcnt = 0; rmod = 0; ndel = 0; nrep = 0; run = 0;
        e_valid = 0; e_bit = 0; e_sof = 0; e_del = 0; e_rep = 0; e_pos = 0;
        repeat (3) @(negedge clk);
        check(!rd_valid && !rd_sof && !slip_delete && !slip_repeat, "R1",
              "flags in reset", {rd_valid, rd_sof, slip_delete, slip_repeat}, 0);
        check(slip_count == '0, "R1", "slip_count in reset", slip_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_valid && slip_count == '0, "R1", "after release",
              {rd_valid, 16'(slip_count)}, 0);
    endtask

    initial begin
        for (int s = 0; s < NSCN; s++) begin
            do_reset();
            // R2: unmarked writes before alignment, reads also issued and ignored
            for (int j = 0; j < 5; j++) step(1'b1, 1'b1, 1'b1);
            // R3: first frame, reads ignored while filling
            for (int j = 0; j < FB; j++) step(1'b1, 1'b1, 1'b0);
            step(1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0);
            run = 1;
            for (int c = 0; c < SCN[s][2]; c++) begin
                bit w;
                bit r;
                w = (c % SCN[s][0]) != SCN[s][0] - 1;
                r = (c % SCN[s][1]) != SCN[s][1] - 1;
                if (c >= PAUSE_AT && c < PAUSE_AT + SCN[s][3]) r = 0;
                if (c >= PAUSE_AT && c < PAUSE_AT + SCN[s][4]) w = 0;
                step(w, r, 1'b0);
            end
            step(1'b0, 1'b0, 1'b0);
            case (SCN[s][5])
                1: begin
                    check(ndel > 0, "R5", "deletes under fast write", ndel, 1);
                    check(nrep == 0, "R5", "repeats under fast write", nrep, 0);
                end
                2: begin
                    check(nrep > 0, "R6", "repeats under slow write", nrep, 1);
                    check(ndel == 0, "R6", "deletes under slow write", ndel, 0);
                end
                default: begin
                    check(ndel + nrep == 0, s == 2 ? "R10" : "R7",
                          "slips at equal rate", ndel + nrep, 0);
                end
            endcase
            check(slip_count == CW'(ndel + nrep), "R8", "final slip_count",
                  slip_count, ndel + nrep);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule